// File: doc/BRIEF.md
# Packet Result and Sense Recorder

This block keeps the outcome of every packet command for a storage-device controller. When the command engine finishes a packet it presents a 16-bit result code: the sense key sits in the low byte and the additional sense code in the high byte. The recorder writes that code into a ten-byte sense record and updates three task-file registers: error, count and status. A nonzero code marks the command as failed. In that case the recorder raises an interrupt request and tells the controller to return to idle. A zero code leaves status as it was, except that the busy and check bits are cleared.

After a power-on or device reset the recorder arms a unit-attention condition. The first packet that is not a sense request is answered with a fixed reset result in place of its own outcome, and that disarms the condition. When a sector read fails, the recorder also stores the failing block address inside the sense record. A host reads the record one byte at a time through a registered read port. The transfer length of a sense request is the requested length clamped to the record size.

Top module: `pkt_sense_rec`

## Requirements
- R1: After `rst_n` low or a one-cycle `dev_rst_i` pulse, all ten sense bytes are 0x00, error is 0x01, count is 0x01, status is 0x00, `irq_o`/`idle_o`/`ua_o` are 0 and the unit-attention condition is armed.
- R2: On any result, sense byte 0 becomes 0xF0, byte 2 takes the code's low byte and byte 8 takes its high byte; bytes 1, 3, 4 and 9 keep their values, and bytes 5 to 7 change only under R6.
- R3: On any result, error becomes the code's bits 3:0 shifted into bits 7:4 with bits 3:0 zero, and count becomes 0x03, visible the cycle after the result is presented.
- R4: A nonzero result sets status to 0x51 and pulses `irq_o` and `idle_o` high for exactly one cycle, starting the cycle after the result.
- R5: A zero result clears status bit 7 (busy) and bit 0 (check), keeps the other six status bits, and raises no interrupt.
- R6: A result presented with `rd_err_i` high writes the 24-bit `rd_lba_i` into sense bytes 5, 6 and 7, most significant byte first.
- R7: While armed, a `pkt_start_i` whose opcode differs from 0x03 (sense request) is recorded as result 0x2906 (sense key 0x06, additional code 0x29). `ua_o` pulses for one cycle and the condition disarms. Opcode 0x03 neither fires nor disarms it, and later packets never fire.
- R8: When a unit-attention packet and a `res_valid_i` result arrive in the same cycle, only the reset result is recorded and no block address is captured.
- R9: `sense_len_o` equals `req_len_i` when that is at most 10, and equals 10 otherwise. It is combinational.
- R10: A read with `sns_rd_i` high returns sense byte `sns_idx_i` on `sns_q_o` the next cycle. An index of 10 or more returns 0x00.
- R11: `stat_wr_i` loads `stat_din_i` into status. A result in the same cycle takes priority over the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_rst_i | input | 1 | Synchronous device reset pulse |
| stat_wr_i | input | 1 | Load status from the controller |
| stat_din_i | input | 8 | Status value to load |
| res_valid_i | input | 1 | Packet result presented this cycle |
| res_code_i | input | 16 | Result: low byte sense key, high byte additional code |
| rd_err_i | input | 1 | Result comes from a failed sector read |
| rd_lba_i | input | 24 | Block address of the failed read |
| pkt_start_i | input | 1 | A packet command has been received |
| pkt_op_i | input | 8 | Opcode of that packet |
| req_len_i | input | 8 | Length requested by a sense request |
| sense_len_o | output | 8 | Clamped sense transfer length |
| sns_rd_i | input | 1 | Sense byte read strobe |
| sns_idx_i | input | 4 | Sense byte index |
| sns_q_o | output | 8 | Registered sense byte |
| err_o | output | 8 | Error register |
| cnt_o | output | 8 | Count register |
| status_o | output | 8 | Status register |
| irq_o | output | 1 | One-cycle interrupt raise |
| idle_o | output | 1 | One-cycle force-to-idle request |
| ua_o | output | 1 | One-cycle reset-result indication |

## Verification
A wrong unit-attention state shows up on the first non-sense packet after reset. `ua_o`, error 0x60 and status 0x51 all appear, or fail to appear, one cycle after that packet. A byte of the sense record that is written when it should not be, or not written when it should, appears on `sns_q_o` one cycle after the host reads that index. For that reason each result is followed by reads of the updated bytes, the bytes that must not change, and the captured address bytes. Priority errors become visible in the register values one cycle after the collision:
- reset result against a normal result;
- result against a status load.

// File: rtl/pkt_sense_pkg.sv
package pkt_sense_pkg;
   localparam logic [7:0] SNS_HDR     = 8'hF0;
   localparam logic [7:0] ST_FAIL     = 8'h51;
   localparam logic [7:0] ST_KEEP     = 8'h7E;
   localparam logic [7:0] RST_ERR     = 8'h01;
   localparam logic [7:0] RST_CNT     = 8'h01;
   localparam logic [7:0] RST_STAT    = 8'h00;
   localparam logic [7:0] DONE_CNT    = 8'h03;

   typedef struct packed {
      logic        vld;
      logic [15:0] code;
      logic        cap;
   } result_t;
endpackage

// File: rtl/psr_attn.sv
module psr_attn #(
   parameter logic [7:0] SENSE_OP = 8'h03
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       dev_rst_i,
   input  logic       pkt_start_i,
   input  logic [7:0] pkt_op_i,
   output logic       fire_o,
   output logic       ua_o
);
   logic armed_q;

   assign fire_o = pkt_start_i & armed_q & (pkt_op_i != SENSE_OP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b1;
         ua_o    <= 1'b0;
      end else if (dev_rst_i) begin
         armed_q <= 1'b1;
         ua_o    <= 1'b0;
      end else begin
         if (fire_o) armed_q <= 1'b0;
         ua_o <= fire_o;
      end
   end

   AST_ATTN_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
      (fire_o && !dev_rst_i) |=> (!armed_q && ua_o)); // R7
   AST_SENSE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_start_i && pkt_op_i == SENSE_OP && !dev_rst_i) |=> (armed_q == $past(armed_q))); // R7
endmodule

// File: rtl/psr_sense_mem.sv
module psr_sense_mem
   import pkt_sense_pkg::*;
#(
   parameter int SENSE_BYTES = 10,
   parameter int LBA_BYTES   = 3,
   parameter int LBA_POS     = 5,
   parameter int KEY_POS     = 2,
   parameter int ASC_POS     = 8,
   localparam int IDX_W      = $clog2(SENSE_BYTES),
   localparam int LBA_W      = LBA_BYTES * 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dev_rst_i,
   input  result_t          res_i,
   input  logic [LBA_W-1:0] lba_i,
   input  logic             rd_i,
   input  logic [IDX_W-1:0] idx_i,
   output logic [7:0]       q_o
);
   localparam logic [IDX_W:0] NBYTES = (IDX_W+1)'(SENSE_BYTES);

   logic [7:0] mem_q [SENSE_BYTES];
   logic [7:0] nxt   [SENSE_BYTES];

   for (genvar i = 0; i < SENSE_BYTES; i++) begin : g_byte
      logic [7:0] upd;
      if (i == 0) begin : g_hdr
         assign upd = SNS_HDR;
      end else if (i == KEY_POS) begin : g_key
         assign upd = res_i.code[7:0];
      end else if (i == ASC_POS) begin : g_asc
         assign upd = res_i.code[15:8];
      end else if (i >= LBA_POS && i < LBA_POS + LBA_BYTES) begin : g_lba
         assign upd = res_i.cap ? lba_i[(LBA_POS+LBA_BYTES-1-i)*8 +: 8] : mem_q[i];
      end else begin : g_keep
         assign upd = mem_q[i];
      end
      assign nxt[i] = res_i.vld ? upd : mem_q[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < SENSE_BYTES; k++) mem_q[k] <= 8'h00;
      end else if (dev_rst_i) begin
         for (int k = 0; k < SENSE_BYTES; k++) mem_q[k] <= 8'h00;
      end else begin
         for (int k = 0; k < SENSE_BYTES; k++) mem_q[k] <= nxt[k];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q_o <= 8'h00;
      else if (rd_i)  q_o <= ({1'b0, idx_i} < NBYTES) ? mem_q[idx_i] : 8'h00;
   end

   AST_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && ({1'b0, idx_i} >= NBYTES)) |=> (q_o == 8'h00)); // R10
   AST_LBA_MSB: assert property (@(posedge clk) disable iff (!rst_n)
      (res_i.vld && res_i.cap && !dev_rst_i) |=> (mem_q[LBA_POS] == $past(lba_i[LBA_W-1 -: 8]))); // R6
   AST_HDR_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (res_i.vld && !dev_rst_i) |=> (mem_q[0] == SNS_HDR)); // R2
endmodule

// File: rtl/psr_taskfile.sv
module psr_taskfile
   import pkt_sense_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       dev_rst_i,
   input  result_t    res_i,
   input  logic       stat_wr_i,
   input  logic [7:0] stat_din_i,
   output logic [7:0] err_o,
   output logic [7:0] cnt_o,
   output logic [7:0] status_o,
   output logic       irq_o,
   output logic       idle_o
);
   logic failed;
   assign failed = (res_i.code != 16'h0000);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_o <= RST_ERR;  cnt_o <= RST_CNT;  status_o <= RST_STAT;
         irq_o <= 1'b0;     idle_o <= 1'b0;
      end else if (dev_rst_i) begin
         err_o <= RST_ERR;  cnt_o <= RST_CNT;  status_o <= RST_STAT;
         irq_o <= 1'b0;     idle_o <= 1'b0;
      end else begin
         irq_o  <= 1'b0;
         idle_o <= 1'b0;
         if (res_i.vld) begin
            err_o <= {res_i.code[3:0], 4'h0};
            cnt_o <= DONE_CNT;
            if (failed) begin
               status_o <= ST_FAIL;
               irq_o    <= 1'b1;
               idle_o   <= 1'b1;
            end else begin
               status_o <= status_o & ST_KEEP;
            end
         end else if (stat_wr_i) begin
            status_o <= stat_din_i;
         end
      end
   end

   AST_ERR_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
      (res_i.vld && !dev_rst_i) |=> (err_o[3:0] == 4'h0 && cnt_o == DONE_CNT)); // R3
   AST_FAIL_STAT: assert property (@(posedge clk) disable iff (!rst_n)
      (res_i.vld && failed && !dev_rst_i) |=> (status_o == ST_FAIL && irq_o && idle_o)); // R4
   AST_ZERO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (res_i.vld && !failed && !dev_rst_i) |=> (!irq_o && status_o[7] == 1'b0 && status_o[0] == 1'b0
                                                && status_o[6:1] == $past(status_o[6:1]))); // R5
   AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> $past(res_i.vld)); // R4
endmodule

// File: rtl/pkt_sense_rec.sv
module pkt_sense_rec
   import pkt_sense_pkg::*;
#(
   parameter int          SENSE_BYTES = 10,
   parameter int          LBA_BYTES   = 3,
   parameter int          LBA_POS     = 5,
   parameter int          KEY_POS     = 2,
   parameter int          ASC_POS     = 8,
   parameter int          LEN_W       = 8,
   parameter logic [7:0]  SENSE_OP    = 8'h03,
   parameter logic [15:0] ATTN_CODE   = 16'h2906,
   localparam int         IDX_W       = $clog2(SENSE_BYTES),
   localparam int         LBA_W       = LBA_BYTES * 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dev_rst_i,
   input  logic             stat_wr_i,
   input  logic [7:0]       stat_din_i,
   input  logic             res_valid_i,
   input  logic [15:0]      res_code_i,
   input  logic             rd_err_i,
   input  logic [LBA_W-1:0] rd_lba_i,
   input  logic             pkt_start_i,
   input  logic [7:0]       pkt_op_i,
   input  logic [LEN_W-1:0] req_len_i,
   output logic [LEN_W-1:0] sense_len_o,
   input  logic             sns_rd_i,
   input  logic [IDX_W-1:0] sns_idx_i,
   output logic [7:0]       sns_q_o,
   output logic [7:0]       err_o,
   output logic [7:0]       cnt_o,
   output logic [7:0]       status_o,
   output logic             irq_o,
   output logic             idle_o,
   output logic             ua_o
);
   localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(SENSE_BYTES);

   if (SENSE_BYTES <= ASC_POS || SENSE_BYTES < LBA_POS + LBA_BYTES || KEY_POS == 0
       || (LBA_POS <= KEY_POS && KEY_POS < LBA_POS + LBA_BYTES)
       || (LBA_POS <= ASC_POS && ASC_POS < LBA_POS + LBA_BYTES)) begin : g_bad_layout
      $error("sense record layout fields overlap or exceed SENSE_BYTES");
   end
   if (LEN_W < IDX_W + 1) begin : g_bad_len
      $error("LEN_W too narrow for SENSE_BYTES");
   end

   logic    attn_fire;
   result_t res;

   psr_attn #(.SENSE_OP(SENSE_OP)) u_attn (
      .clk(clk), .rst_n(rst_n), .dev_rst_i(dev_rst_i),
      .pkt_start_i(pkt_start_i), .pkt_op_i(pkt_op_i),
      .fire_o(attn_fire), .ua_o(ua_o));

   always_comb begin
      res.vld  = attn_fire | res_valid_i;
      res.code = attn_fire ? ATTN_CODE : res_code_i;
      res.cap  = res_valid_i & rd_err_i & ~attn_fire;
   end

   psr_sense_mem #(
      .SENSE_BYTES(SENSE_BYTES), .LBA_BYTES(LBA_BYTES), .LBA_POS(LBA_POS),
      .KEY_POS(KEY_POS), .ASC_POS(ASC_POS)
   ) u_mem (
      .clk(clk), .rst_n(rst_n), .dev_rst_i(dev_rst_i),
      .res_i(res), .lba_i(rd_lba_i),
      .rd_i(sns_rd_i), .idx_i(sns_idx_i), .q_o(sns_q_o));

   psr_taskfile u_tf (
      .clk(clk), .rst_n(rst_n), .dev_rst_i(dev_rst_i),
      .res_i(res), .stat_wr_i(stat_wr_i), .stat_din_i(stat_din_i),
      .err_o(err_o), .cnt_o(cnt_o), .status_o(status_o),
      .irq_o(irq_o), .idle_o(idle_o));

   assign sense_len_o = (req_len_i > LEN_MAX) ? LEN_MAX : req_len_i;

   AST_LEN_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
      (sense_len_o <= LEN_MAX) && (sense_len_o <= req_len_i)); // R9
   AST_ATTN_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (attn_fire && res_valid_i && !dev_rst_i) |=> (err_o == {ATTN_CODE[3:0], 4'h0})); // R8
   AST_LOAD_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr_i && !res.vld && !dev_rst_i) |=> (status_o == $past(stat_din_i))); // R11
endmodule

// File: tb/sim_pkt_sense_rec.sv
module sim_pkt_sense_rec;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 8;
   // {code[15:0], rd_err, lba[23:0], status loaded before the result}
   localparam logic [48:0] VEC [NVEC] = '{
      {16'h0000, 1'b0, 24'h000000, 8'hD9},
      {16'h3A02, 1'b0, 24'h000000, 8'h58},
      {16'h1105, 1'b1, 24'h123456, 8'h58},
      {16'h0000, 1'b0, 24'h000000, 8'h80},
      {16'h0000, 1'b0, 24'h000000, 8'h01},
      {16'hFFFF, 1'b1, 24'hABCDEF, 8'hFF},
      {16'h0000, 1'b1, 24'h999999, 8'hFF},
      {16'h000B, 1'b0, 24'h000000, 8'h40}
   };

   logic clk = 0, rst_n = 0, dev_rst = 0, stat_wr = 0, res_valid = 0, rd_err = 0;
   logic pkt_start = 0, sns_rd = 0;
   logic [7:0] stat_din = 0, pkt_op = 0, req_len = 0, sense_len, sns_q, err, cnt, status;
   logic [15:0] res_code = 0;
   logic [23:0] rd_lba = 0, lba_model = 0;
   logic [3:0] sns_idx = 0;
   logic irq, idle, ua;
   int nchk = 0, nbad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pkt_sense_rec u0 (
      .clk(clk), .rst_n(rst_n), .dev_rst_i(dev_rst), .stat_wr_i(stat_wr), .stat_din_i(stat_din),
      .res_valid_i(res_valid), .res_code_i(res_code), .rd_err_i(rd_err), .rd_lba_i(rd_lba),
      .pkt_start_i(pkt_start), .pkt_op_i(pkt_op), .req_len_i(req_len), .sense_len_o(sense_len),
      .sns_rd_i(sns_rd), .sns_idx_i(sns_idx), .sns_q_o(sns_q), .err_o(err), .cnt_o(cnt),
      .status_o(status), .irq_o(irq), .idle_o(idle), .ua_o(ua));

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s: actual %0h expected %0h", what, act, exp);
      end
   endtask

   task automatic rd_byte(input int idx, output logic [7:0] v);
      @(negedge clk); sns_rd = 1; sns_idx = 4'(idx);
      @(negedge clk); sns_rd = 0; v = sns_q;
   endtask

   task automatic chk_byte(input string what, input int idx, input logic [7:0] exp);
      logic [7:0] v;
      rd_byte(idx, v);
      chk(what, {24'h0, v}, {24'h0, exp});
   endtask

   task automatic post(input logic [15:0] c, input logic e, input logic [23:0] a);
      @(negedge clk); res_valid = 1; res_code = c; rd_err = e; rd_lba = a;
      @(negedge clk); res_valid = 0; rd_err = 0;
   endtask

   task automatic packet(input logic [7:0] op);
      @(negedge clk); pkt_start = 1; pkt_op = op;
      @(negedge clk); pkt_start = 0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      nbad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
   end

   initial begin
      logic [7:0] st_exp;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset values
      chk("R1 error", {24'h0, err}, 32'h01);
      chk("R1 count", {24'h0, cnt}, 32'h01);
      chk("R1 status", {24'h0, status}, 32'h00);
      chk("R1 irq/idle/ua", {29'h0, irq, idle, ua}, 32'h0);
      for (int i = 0; i < 10; i++) chk_byte("R1 sense zero", i, 8'h00);

      // R7 sense request does not consume the attention
      packet(8'h03);
      chk("R7 sense op no ua", {31'h0, ua}, 32'h0);
      chk("R7 sense op status", {24'h0, status}, 32'h00);
      packet(8'h12);
      chk("R7 ua pulse", {31'h0, ua}, 32'h1);
      chk("R7 reset error", {24'h0, err}, 32'h60);
      chk("R7 reset status", {24'h0, status}, 32'h51);
      chk("R7 irq", {31'h0, irq}, 32'h1);
      chk_byte("R7 key byte", 2, 8'h06);
      chk_byte("R7 asc byte", 8, 8'h29);
      packet(8'h12);
      chk("R7 second packet no ua", {31'h0, ua}, 32'h0);
      chk("R7 second packet no irq", {31'h0, irq}, 32'h0);

      // table of results: R2 R3 R4 R5 R6
      for (int v = 0; v < NVEC; v++) begin
         logic [15:0] c; logic e; logic [23:0] a; logic [7:0] pre;
         {c, e, a, pre} = VEC[v];
         @(negedge clk); stat_wr = 1; stat_din = pre;
         @(negedge clk); stat_wr = 0;
         post(c, e, a);
         if (e) lba_model = a;
         st_exp = (c != 0) ? 8'h51 : (pre & 8'h7E);
         chk("R3 error", {24'h0, err}, {24'h0, c[3:0], 4'h0});
         chk("R3 count", {24'h0, cnt}, 32'h03);
         chk("R4/R5 status", {24'h0, status}, {24'h0, st_exp});
         chk("R4 irq", {31'h0, irq}, {31'h0, c != 0});
         chk("R4 idle", {31'h0, idle}, {31'h0, c != 0});
         chk_byte("R2 byte0", 0, 8'hF0);
         chk_byte("R2 key byte", 2, c[7:0]);
         chk_byte("R2 asc byte", 8, c[15:8]);
         chk_byte("R2 byte1 kept", 1, 8'h00);
         chk_byte("R2 byte9 kept", 9, 8'h00);
         chk_byte("R6 lba msb", 5, lba_model[23:16]);
         chk_byte("R6 lba mid", 6, lba_model[15:8]);
         chk_byte("R6 lba lsb", 7, lba_model[7:0]);
      end
      chk("R4 irq single cycle", {31'h0, irq}, 32'h0);

      // R11 status load and its priority
      @(negedge clk); stat_wr = 1; stat_din = 8'hA5;
      @(negedge clk); stat_wr = 0;
      chk("R11 status load", {24'h0, status}, 32'hA5);
      @(negedge clk); stat_wr = 1; stat_din = 8'h33; res_valid = 1; res_code = 16'h0000;
      @(negedge clk); stat_wr = 0; res_valid = 0;
      chk("R11 result wins over load", {24'h0, status}, 32'h24);

      // R1 device reset, then R8 collision
      @(negedge clk); dev_rst = 1;
      @(negedge clk); dev_rst = 0;
      chk("R1 dev reset error", {24'h0, err}, 32'h01);
      chk("R1 dev reset count", {24'h0, cnt}, 32'h01);
      chk("R1 dev reset status", {24'h0, status}, 32'h00);
      chk_byte("R1 dev reset lba byte", 5, 8'h00);
      @(negedge clk); pkt_start = 1; pkt_op = 8'h28;
      res_valid = 1; res_code = 16'h0000; rd_err = 1; rd_lba = 24'h777777;
      @(negedge clk); pkt_start = 0; res_valid = 0; rd_err = 0;
      chk("R8 ua wins", {31'h0, ua}, 32'h1);
      chk("R8 error", {24'h0, err}, 32'h60);
      chk("R8 status", {24'h0, status}, 32'h51);
      chk_byte("R8 key byte", 2, 8'h06);
      chk_byte("R8 no lba capture", 5, 8'h00);

      // R9 clamp
      foreach (VEC[i]) begin end
      begin
         logic [7:0] lens [5] = '{8'd0, 8'd9, 8'd10, 8'd11, 8'd255};
         for (int i = 0; i < 5; i++) begin
            @(negedge clk); req_len = lens[i]; #1;
            chk("R9 length clamp", {24'h0, sense_len}, {24'h0, (lens[i] > 8'd10) ? 8'd10 : lens[i]});
         end
      end

      // R10 out-of-range index
      chk_byte("R10 index 10", 10, 8'h00);
      chk_byte("R10 index 15", 15, 8'h00);
      chk_byte("R10 in range", 0, 8'hF0);

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
   end
endmodule